// File: doc/BRIEF.md
# Warp Issue Scheduler

This block chooses, every clock cycle, at most one warp out of a pool of hardware thread contexts in a single SIMT core and presents that warp's identifier and program counter for instruction issue. Each warp stands for 32 threads that execute in lockstep as one 32-lane operation. The pool holds 24 contexts by default, so 24 independent instruction streams share one issue slot. Every context keeps its own program counter. All threads of a warp start at the address given when the warp is launched.

A context may issue only when it is occupied and its next instruction has no register hazard. A small per-warp scoreboard provides this check. When a warp issues an instruction that writes a register, that register is marked pending. A later writeback notification, tagged with the warp and register, clears the mark. The upstream decode stage supplies the operand registers of each warp's next instruction on flat per-warp buses. Among the eligible warps, selection rotates: the search begins at the warp after the one that issued last. A global stall input holds off issue without losing any state.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no context is occupied, `issue_valid` is low, and the first rotation search starts at warp 0.
- R2: A launch to an unoccupied slot marks it occupied and loads its program counter with `launch_pc`. The warp's first issue presents exactly that address.
- R3: A launch to an occupied slot is ignored. The slot's program counter and its place in the rotation stay unchanged.
- R4: Each issue advances the issuing warp's program counter by 4. The counters of all other warps are unchanged.
- R5: Selection is round-robin. The search starts at the warp numbered one above the last issuing warp, wraps from the highest index to 0, and grants the first eligible warp it finds.
- R6: While `stall` is high, `issue_valid` is low, no program counter changes, and the rotation position is held.
- R7: An issued instruction with its write-enable set marks its destination register pending for that warp only. A warp is not eligible while either source register is pending, or while its write-enabled destination register is pending.
- R8: A writeback notification clears the named register's pending mark for the named warp. The warp can issue in the cycle after the notification.
- R9: When no occupied warp is free of hazards, `issue_valid` stays low and no program counter changes.
- R10: A launched warp first becomes eligible in the cycle after its launch request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request strobe |
| launch_warp | input | 5 | Slot index to launch into |
| launch_pc | input | 32 | Start address for the launched warp |
| stall | input | 1 | Holds off all issue while high |
| nxt_src_a | input | 96 | Per-warp first source register of the next instruction, 4 bits per warp, warp i at bits [4i+3:4i] |
| nxt_src_b | input | 96 | Per-warp second source register, same layout |
| nxt_dst | input | 96 | Per-warp destination register, same layout |
| nxt_wr_en | input | 24 | Per-warp destination write enable, bit i for warp i |
| wb_valid | input | 1 | Writeback notification strobe |
| wb_warp | input | 5 | Warp that owns the written-back register |
| wb_reg | input | 4 | Register that was written back |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_warp | output | 5 | Index of the issued warp |
| issue_pc | output | 32 | Program counter of the issued warp |

## Verification
The bench targets the rotation's wrap and skip behaviour. A picker that restarted from warp 0, or that resumed at the last winner instead of the next warp, would issue the warps out of the expected order. A stalled cycle must neither move the rotation nor advance a counter, and a design that updated the pointer during stall would skip a warp. For the scoreboard, the bench checks three cases: a pending register blocks only its own warp, a writeback frees that warp in the next cycle, and a warp launched while every other warp is blocked does not issue in its launch cycle. It also relaunches an occupied slot with a new address, and a design that accepted the relaunch would show the wrong address on that warp's next issue.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  localparam int PC_W    = 32;
  localparam int REG_CNT = 16;
  localparam int REG_W   = $clog2(REG_CNT);

  typedef logic [PC_W-1:0]    pc_t;
  typedef logic [REG_W-1:0]   reg_id_t;
  typedef logic [REG_CNT-1:0] reg_mask_t;

  localparam pc_t PC_STEP = pc_t'(4);

  // Program counter after one issued instruction.
  function automatic pc_t pc_advance(pc_t pc);
    return pc + PC_STEP;
  endfunction

  // True when the next instruction touches a register still in flight.
  function automatic logic operand_hazard(reg_mask_t pend, reg_id_t ra,
                                          reg_id_t rb, reg_id_t rd, logic wen);
    return pend[ra] | pend[rb] | (wen & pend[rd]);
  endfunction

  // Ring position base+off for base < n and off <= n.
  function automatic int ring_add(int base, int off, int n);
    int s;
    s = base + off;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/warp_slot.sv
module warp_slot
  import warp_sched_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    launch_hit,
  input  pc_t     launch_pc,
  input  logic    issue_hit,
  input  logic    wb_hit,
  input  reg_id_t wb_reg,
  input  reg_id_t src_a,
  input  reg_id_t src_b,
  input  reg_id_t dst,
  input  logic    wr_en,
  output logic    valid,
  output logic    ready,
  output pc_t     pc
);
  logic      valid_q;
  pc_t       pc_q;
  reg_mask_t pending_q;
  reg_mask_t pending_d;
  logic      launch_take;
  logic      hazard;

  assign launch_take = launch_hit && !valid_q;
  assign hazard      = operand_hazard(pending_q, src_a, src_b, dst, wr_en);
  assign valid       = valid_q;
  assign ready       = valid_q && !hazard;
  assign pc          = pc_q;

  always_comb begin
    pending_d = pending_q;
    if (wb_hit) pending_d[wb_reg] = 1'b0;
    if (issue_hit && wr_en) pending_d[dst] = 1'b1;
    if (launch_take) pending_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      pc_q      <= '0;
      pending_q <= '0;
    end else begin
      pending_q <= pending_d;
      if (launch_take) begin
        valid_q <= 1'b1;
        pc_q    <= launch_pc;
      end else if (issue_hit) begin
        pc_q <= pc_advance(pc_q);
      end
    end
  end

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_hit |=> pc_q == pc_advance($past(pc_q)));

  // R3
  occupied_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && launch_hit && !issue_hit) |=> ($stable(pc_q) && valid_q));

  // R7
  hazard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q[src_a] || pending_q[src_b]) |-> !ready);

  // R7
  pending_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_hit && wr_en) |=> pending_q[$past(dst)]);

  // R8
  wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_hit && !(issue_hit && wr_en && dst == wb_reg)) |=> !pending_q[$past(wb_reg)]);

  // R2
  idle_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> !ready);
endmodule

// File: rtl/rr_picker.sv
module rr_picker
  import warp_sched_pkg::*;
#(
  parameter int N     = 24,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] last,
  output logic             gnt_valid,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] cand;
  logic [IDX_W-1:0] first_cand;

  assign first_cand = IDX_W'(ring_add(int'(last), 1, N));

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    cand      = '0;
    for (int off = 1; off <= N; off++) begin
      cand = IDX_W'(ring_add(int'(last), off, N));
      if (!gnt_valid && req[cand]) begin
        gnt_valid = 1'b1;
        gnt_idx   = cand;
      end
    end
  end

  // R5
  grant_is_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req[gnt_idx]);

  // R5
  next_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req[first_cand] |-> (gnt_valid && gnt_idx == first_cand));

  // R9
  no_req_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !gnt_valid);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 24,
  localparam int IDX_W    = $clog2(NUM_WARPS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       launch_valid,
  input  logic [IDX_W-1:0]           launch_warp,
  input  logic [PC_W-1:0]            launch_pc,
  input  logic                       stall,
  input  logic [NUM_WARPS*REG_W-1:0] nxt_src_a,
  input  logic [NUM_WARPS*REG_W-1:0] nxt_src_b,
  input  logic [NUM_WARPS*REG_W-1:0] nxt_dst,
  input  logic [NUM_WARPS-1:0]       nxt_wr_en,
  input  logic                       wb_valid,
  input  logic [IDX_W-1:0]           wb_warp,
  input  logic [REG_W-1:0]           wb_reg,
  output logic                       issue_valid,
  output logic [IDX_W-1:0]           issue_warp,
  output logic [PC_W-1:0]            issue_pc
);
  logic [NUM_WARPS-1:0] slot_valid;
  logic [NUM_WARPS-1:0] slot_ready;
  logic [NUM_WARPS-1:0] issue_hit;
  pc_t                  slot_pc [NUM_WARPS];
  logic [IDX_W-1:0]     last_q;
  logic                 gnt_valid;
  logic [IDX_W-1:0]     gnt_idx;

  for (genvar i = 0; i < NUM_WARPS; i++) begin : g_slot
    logic launch_hit_w;
    logic wb_hit_w;
    assign launch_hit_w = launch_valid && (launch_warp == IDX_W'(i));
    assign wb_hit_w     = wb_valid && (wb_warp == IDX_W'(i));
    assign issue_hit[i] = issue_valid && (gnt_idx == IDX_W'(i));

    warp_slot i_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_hit (launch_hit_w),
      .launch_pc  (launch_pc),
      .issue_hit  (issue_hit[i]),
      .wb_hit     (wb_hit_w),
      .wb_reg     (wb_reg),
      .src_a      (nxt_src_a[i*REG_W +: REG_W]),
      .src_b      (nxt_src_b[i*REG_W +: REG_W]),
      .dst        (nxt_dst[i*REG_W +: REG_W]),
      .wr_en      (nxt_wr_en[i]),
      .valid      (slot_valid[i]),
      .ready      (slot_ready[i]),
      .pc         (slot_pc[i])
    );
  end

  rr_picker #(.N(NUM_WARPS)) i_picker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (slot_ready),
    .last      (last_q),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  assign issue_valid = gnt_valid && !stall;
  assign issue_warp  = gnt_idx;
  assign issue_pc    = slot_pc[gnt_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IDX_W'(NUM_WARPS - 1);
    else if (issue_valid) last_q <= gnt_idx;
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !issue_valid);

  // R6
  stall_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(last_q));

  // R5
  single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_hit));

  // R2
  issue_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> slot_valid[issue_warp]);
endmodule

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;
  localparam int NW = 24;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          launch_valid;
  logic [4:0]    launch_warp;
  logic [31:0]   launch_pc;
  logic          stall;
  logic [NW*RW-1:0] nxt_src_a, nxt_src_b, nxt_dst;
  logic [NW-1:0] nxt_wr_en;
  logic          wb_valid;
  logic [4:0]    wb_warp;
  logic [3:0]    wb_reg;
  logic          issue_valid;
  logic [4:0]    issue_warp;
  logic [31:0]   issue_pc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  warp_issue_sched i_warp_issue_sched (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_warp(launch_warp),
    .launch_pc(launch_pc), .stall(stall), .nxt_src_a(nxt_src_a), .nxt_src_b(nxt_src_b),
    .nxt_dst(nxt_dst), .nxt_wr_en(nxt_wr_en), .wb_valid(wb_valid), .wb_warp(wb_warp),
    .wb_reg(wb_reg), .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_pc(issue_pc)
  );

  // {stall, expected valid, expected warp, expected pc}
  localparam logic [38:0] TBL [9] = '{
    {1'b0, 1'b1, 5'd0, 32'h100},
    {1'b0, 1'b1, 5'd1, 32'h200},
    {1'b1, 1'b0, 5'd0, 32'h0},
    {1'b0, 1'b1, 5'd2, 32'h300},
    {1'b0, 1'b1, 5'd0, 32'h104},
    {1'b1, 1'b0, 5'd0, 32'h0},
    {1'b0, 1'b1, 5'd1, 32'h204},
    {1'b0, 1'b1, 5'd2, 32'h304},
    {1'b0, 1'b1, 5'd0, 32'h108}
  };

  task automatic chk(string tag, logic ev, logic [4:0] ew, logic [31:0] epc);
    checks++;
    if (issue_valid !== ev || (ev && (issue_warp !== ew || issue_pc !== epc))) begin
      errors++;
      $display("FAIL %s: got valid=%0b warp=%0d pc=%h, expected valid=%0b warp=%0d pc=%h",
               tag, issue_valid, issue_warp, issue_pc, ev, ew, epc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_nxt(int w, logic [3:0] a, logic [3:0] b, logic [3:0] d, logic en);
    nxt_src_a[w*RW +: RW] = a;
    nxt_src_b[w*RW +: RW] = b;
    nxt_dst[w*RW +: RW]   = d;
    nxt_wr_en[w]          = en;
  endtask

  task automatic launch(logic [4:0] w, logic [31:0] pc);
    launch_valid = 1'b1;
    launch_warp  = w;
    launch_pc    = pc;
    step();
    launch_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; launch_valid = 1'b0; launch_warp = '0; launch_pc = '0;
    stall = 1'b0; wb_valid = 1'b0; wb_warp = '0; wb_reg = '0;
    for (int w = 0; w < NW; w++) set_nxt(w, 4'd1, 4'd2, 4'd3, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset idle", 1'b0, 5'd0, 32'h0);

    stall = 1'b1;
    launch(5'd0, 32'h100);
    launch(5'd1, 32'h200);
    launch(5'd2, 32'h300);
    #1 chk("R6 stalled with warps ready", 1'b0, 5'd0, 32'h0);
    launch(5'd1, 32'h999);   // R3 relaunch into occupied slot

    // R2 R3 R4 R5 R6: rotation table
    for (int i = 0; i < 9; i++) begin
      stall = TBL[i][38];
      #1 chk($sformatf("R5 table row %0d", i), TBL[i][37], TBL[i][36:32], TBL[i][31:0]);
      step();
    end

    // R7: warp 1 writes r5, then reads it
    stall = 1'b0;
    set_nxt(1, 4'd1, 4'd2, 4'd5, 1'b1);
    #1 chk("R7 issue marking r5", 1'b1, 5'd1, 32'h208);
    step();
    set_nxt(1, 4'd5, 4'd2, 4'd3, 1'b0);
    #1 chk("R7 other warp unaffected", 1'b1, 5'd2, 32'h308);
    step();
    #1 chk("R5 wrap to warp 0", 1'b1, 5'd0, 32'h10c);
    step();
    #1 chk("R7 warp 1 skipped", 1'b1, 5'd2, 32'h30c);
    step();
    #1 chk("R4 warp 0 advance", 1'b1, 5'd0, 32'h110);
    step();
    wb_valid = 1'b1; wb_warp = 5'd1; wb_reg = 4'd5;
    #1 chk("R7 warp 1 still skipped", 1'b1, 5'd2, 32'h310);
    step();
    wb_valid = 1'b0;
    #1 chk("R5 after wb cycle", 1'b1, 5'd0, 32'h114);
    step();
    #1 chk("R8 warp 1 freed by writeback", 1'b1, 5'd1, 32'h20c);
    step();

    // R9 R10: block every warp on r6
    for (int w = 0; w < 3; w++) set_nxt(w, 4'd1, 4'd2, 4'd6, 1'b1);
    #1 chk("R5 rotation F", 1'b1, 5'd2, 32'h314);
    step();
    #1 chk("R5 rotation G", 1'b1, 5'd0, 32'h118);
    step();
    #1 chk("R5 rotation H", 1'b1, 5'd1, 32'h210);
    step();
    launch_valid = 1'b1; launch_warp = 5'd3; launch_pc = 32'h400;
    #1 chk("R9 R10 all blocked, launch cycle", 1'b0, 5'd0, 32'h0);
    step();
    launch_valid = 1'b0;
    wb_valid = 1'b1; wb_warp = 5'd0; wb_reg = 4'd6;
    #1 chk("R10 launched warp issues", 1'b1, 5'd3, 32'h400);
    step();
    wb_valid = 1'b0;
    #1 chk("R8 warp 0 freed, wrap", 1'b1, 5'd0, 32'h11c);
    step();
    #1 chk("R9 only warp 3 eligible", 1'b1, 5'd3, 32'h404);
    step();
    #1 chk("R4 warp 3 again", 1'b1, 5'd3, 32'h408);
    step();
    finish_run();
  end
endmodule